// File: doc/BRIEF.md
# Port Interrupt Enable and Line Steering

This block holds the interrupt enable mask of one port and turns the port's status bits into a request on one of four shared active-low interrupt lines. Software reaches the mask through two bus addresses. A write to the set address turns on every enable bit whose write-data bit is 1. A write to the clear address turns off every enable bit whose write-data bit is 1. Enable bits written as 0 keep their value. Both addresses read back the same word. That word holds the enable bits and a two-bit steering field that picks the output line.

The port raises a request when any enabled status bit is high. Three status positions have no enable bit: 8, 9 and 10. Their requests come in already qualified by threshold logic outside this block, and they always pass through. The status register and the threshold logic are not part of this block. Their outputs come in as plain input signals. Only one write can reach the block in any cycle. When set and clear writes come from a shared bus, they are therefore applied one at a time, in bus order.

Top module: `port_irq_steer`

## Requirements
- R1: After reset, the enable bits and the steering field are 0, a read at either address returns 0x0000_0000, and all four lines `irq_line_n` are high.
- R2: A write to address 0x1010 sets each enable bit at positions 11 and 7:0 whose write-data bit is 1. All other enable bits keep their value.
- R3: A write to address 0x1014 clears each enable bit at positions 11 and 7:0 whose write-data bit is 1. All other enable bits keep their value.
- R4: With `bus_addr` at 0x1010 or at 0x1014, `rd_data` returns the same word. For any other address, `rd_data` is 0.
- R5: Bits 29:12 and 10:8 of the read word are always 0. Writing 1s to those positions has no effect.
- R6: A write to either address loads bits 31:30 of the write data straight into the steering field, which reads back at bits 31:30. These two bits are never treated as set or clear bits.
- R7: The port request is the OR of `status_in[11]` and `status_in[7:0]`, each ANDed with its enable bit, together with `thr_hit[2:0]`. The values of `status_in[10:8]` have no effect.
- R8: While the request is active, only line `irq_line_n[steer]` is low (00 selects line 0, 01 line 1, 10 line 2, 11 line 3). While the request is inactive, all four lines are high. The lines follow the inputs in the same cycle.
- R9: A write to any address other than 0x1010 or 0x1014 changes neither the enable bits nor the steering field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `bus_addr` |
| status_in | input | 12 | Port interrupt status bits (bits 10:8 unused) |
| thr_hit | input | 3 | Threshold-qualified requests for status positions 8 to 10 |
| irq_line_n | output | 4 | Shared active-low interrupt lines |

## Verification
A wrong enable bit shows up in the read word on the cycle after the write that caused it. It also shows up on the lines as soon as the matching status bit is driven. A wrong steering value pulls the wrong line low, or two lines low, in the first cycle the request is active. Write leakage shows up right away in the read-back that follows the write: a bit the set or clear path should not have touched, a reserved bit, or a write to a foreign address.

// File: rtl/piesr_pkg.sv
package piesr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STAT_W   = 12;
    localparam int unsigned THR_W    = 3;
    localparam int unsigned STEER_W  = 2;
    localparam int unsigned STEER_LSB = WORD_W - STEER_W;
    // enable bits live at 11 and 7:0
    localparam logic [WORD_W-1:0] ENA_MASK = 32'h0000_08FF;
endpackage

// File: rtl/piesr_regfile.sv
module piesr_regfile
    import piesr_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SET_ADDR = 16'h1010,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h1014
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    output logic [WORD_W-1:0]   ena_word,
    output logic [STEER_W-1:0]  steer
);
    logic hit_set, hit_clr, hit_any;
    logic [WORD_W-1:0] wr_bits;

    assign hit_set = (bus_addr == SET_ADDR);
    assign hit_clr = (bus_addr == CLR_ADDR);
    assign hit_any = hit_set || hit_clr;
    assign wr_bits = wr_data & ENA_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_word <= '0;
            steer    <= '0;
        end else if (wr_en && hit_any) begin
            steer <= wr_data[STEER_LSB +: STEER_W];
            if (hit_set) ena_word <= ena_word | wr_bits;
            else         ena_word <= ena_word & ~wr_bits;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit_any) begin
            rd_data = ena_word;
            rd_data[STEER_LSB +: STEER_W] = steer;
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_set) |=> ((ena_word & $past(wr_bits)) == $past(wr_bits)));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_clr) |=> ((ena_word & $past(wr_bits)) == '0));
    // R6
    steer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_any) |=> (steer == $past(wr_data[STEER_LSB +: STEER_W])));
    // R9
    no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_any) |=> ($stable(ena_word) && $stable(steer)));
    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'h3FFF_F700) == '0);
endmodule

// File: rtl/piesr_merge.sv
module piesr_merge
    import piesr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STAT_W-1:0]  status_in,
    input  logic [THR_W-1:0]   thr_hit,
    input  logic [WORD_W-1:0]  ena_word,
    output logic               port_irq
);
    logic [STAT_W-1:0] gated;

    assign gated    = status_in & ena_word[STAT_W-1:0] & ENA_MASK[STAT_W-1:0];
    assign port_irq = (|gated) || (|thr_hit);

    // R7
    thr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|thr_hit) |-> port_irq);
    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_in & ena_word[STAT_W-1:0]) == '0 && thr_hit == '0) |-> !port_irq);
endmodule

// File: rtl/piesr_router.sv
module piesr_router #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned SEL_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_irq,
    input  logic [SEL_W-1:0]     steer,
    output logic [NUM_LINES-1:0] line_n
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign line_n[i] = !(port_irq && (steer == SEL_W'(i)));
    end

    // R8
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~line_n) <= 1);
    // R8
    sel_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq |-> !line_n[steer]);
    // R8
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_irq |-> (&line_n));
endmodule

// File: rtl/port_irq_steer.sv
module port_irq_steer
    import piesr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1010,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h1014,
    parameter int unsigned       NUM_LINES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    input  logic [11:0]           status_in,
    input  logic [2:0]            thr_hit,
    output logic [NUM_LINES-1:0]  irq_line_n
);
    logic [WORD_W-1:0]  ena_word;
    logic [STEER_W-1:0] steer;
    logic               port_irq;

    piesr_regfile #(
        .ADDR_W  (ADDR_W),
        .SET_ADDR(SET_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_addr(bus_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ena_word(ena_word),
        .steer   (steer)
    );

    piesr_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_in(status_in),
        .thr_hit  (thr_hit),
        .ena_word (ena_word),
        .port_irq (port_irq)
    );

    piesr_router #(
        .NUM_LINES(NUM_LINES),
        .SEL_W    (STEER_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_irq(port_irq),
        .steer   (steer),
        .line_n  (irq_line_n)
    );
endmodule

// File: tb/port_irq_steer_tb.sv
`timescale 1ns/100ps
module port_irq_steer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [11:0] status_in = '0;
    logic [2:0]  thr_hit = '0;
    logic [3:0]  irq_line_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_ena = '0;
    logic [1:0]  m_steer = '0;

    localparam logic [15:0] A_SET = 16'h1010;
    localparam logic [15:0] A_CLR = 16'h1014;
    localparam logic [31:0] MSK   = 32'h0000_08FF;

    always #2.5 clk = ~clk;

    port_irq_steer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .status_in(status_in),
        .thr_hit(thr_hit), .irq_line_n(irq_line_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_word();
        return {m_steer, 30'h0} | m_ena;
    endfunction

    function automatic logic [3:0] m_lines();
        logic irq;
        irq = (|(status_in & m_ena[11:0] & MSK[11:0])) || (|thr_hit);
        return irq ? ~(4'b0001 << m_steer) : 4'hF;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == A_SET) begin
            m_ena = m_ena | (d & MSK); m_steer = d[31:30];
        end else if (a == A_CLR) begin
            m_ena = m_ena & ~(d & MSK); m_steer = d[31:30];
        end
    endtask

    task automatic rd_both(input string req);
        bus_addr = A_SET; #1;
        chk(req, rd_data, m_word());
        bus_addr = A_CLR; #1;
        chk(req, rd_data, m_word());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_both("R1 reset read");
        chk("R1 reset lines", {28'h0, irq_line_n}, 32'hF);

        // R2 R5 R4 set sweep, every bit position, steering held at 0
        for (int b = 0; b < 30; b++) begin
            wr(A_SET, 32'h1 << b);
            rd_both("R2 R5 set sweep");
        end
        // R3 clear sweep
        for (int b = 0; b < 30; b++) begin
            wr(A_CLR, 32'h1 << b);
            rd_both("R3 R5 clear sweep");
        end
        // R6 steering through both addresses, not set/clear
        for (int s = 0; s < 4; s++) begin
            wr((s % 2 == 0) ? A_SET : A_CLR, {2'(s), 30'h0});
            rd_both("R6 steer load");
        end
        wr(A_SET, 32'hFFFF_FFFF);
        rd_both("R2 R5 set all");
        wr(A_CLR, 32'h0000_0000);
        rd_both("R6 steer zero on clear write");
        // R9 foreign addresses ignored
        wr(16'h1018, 32'hC000_0000);
        wr(16'h1000, 32'h0000_0000);
        wr(16'h1011, 32'hFFFF_FFFF);
        rd_both("R9 foreign write");
        // R4 other address reads zero
        bus_addr = 16'h1020; #1;
        chk("R4 foreign read", rd_data, 32'h0);
        bus_addr = 16'h1012; #1;
        chk("R4 foreign read", rd_data, 32'h0);

        // R7 R8 line sweep over steering, enable patterns and sources
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 3; p++) begin
                logic [31:0] pat;
                pat = (p == 0) ? 32'h0000_08FF : (p == 1) ? 32'h0000_00AA : 32'h0000_0855;
                wr(A_CLR, {2'(s), 30'h3FFF_FFFF});
                wr(A_SET, {2'(s), 30'h0} | pat);
                for (int b = 0; b < 12; b++) begin
                    @(negedge clk);
                    status_in = 12'h1 << b; thr_hit = '0; #1;
                    chk("R7 R8 status bit", {28'h0, irq_line_n}, {28'h0, m_lines()});
                end
                for (int t = 0; t < 3; t++) begin
                    @(negedge clk);
                    status_in = '0; thr_hit = 3'h1 << t; #1;
                    chk("R7 R8 threshold bit", {28'h0, irq_line_n}, {28'h0, m_lines()});
                end
                @(negedge clk);
                status_in = 12'h700; thr_hit = '0; #1;
                chk("R7 status 10:8 ignored", {28'h0, irq_line_n}, 32'hF);
                status_in = 12'hFFF; #1;
                chk("R8 all status", {28'h0, irq_line_n}, {28'h0, m_lines()});
                status_in = '0; #1;
                chk("R8 idle", {28'h0, irq_line_n}, 32'hF);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule